// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the register-register integer execution stage of a 32-bit processor pipeline. Each cycle it takes an instruction word and the two source operand values, the first source and the second source. It decodes the function field of the register-format major opcode. For the add, subtract, bitwise and set-on-less-than operations it produces a result and a register write enable. For the conditional trap operations it evaluates the comparison and raises a trap flag.

Every output is registered. The outcome for the inputs presented at one rising edge appears after that edge and holds until the next one. The block reports only which exceptional condition arose: signed arithmetic overflow, a taken trap, or a reserved encoding. Operand fetch, writeback and exception dispatch belong to the surrounding pipeline. When `wr_en` is low, `result` is zero.

Top module: `int_alu`

## Requirements
- R1: With major opcode (bits 31:26) zero and shift field (bits 10:6) zero, function codes 0x20..0x27 select checked add, wrapping add, checked subtract, wrapping subtract, AND, OR, XOR and NOR. Each one with no overflow sets `wr_en` and drives its value on `result`. NOR yields ~(a | b), so NOR against zero is a bitwise NOT.
- R2: Checked add (0x20) and checked subtract (0x22) form a 33-bit sign-extended result. When bits 32 and 31 of it disagree, `ovf` is 1, `wr_en` is 0 and `result` is 0.
- R3: Wrapping add (0x21) and wrapping subtract (0x23) produce the sum or difference modulo 2^32 and never raise `ovf`.
- R4: Function 0x2A writes 1 when the first source is below the second as signed two's-complement values, otherwise 0. Function 0x2B does the same comparison unsigned.
- R5: Trap codes 0x30 signed >=, 0x31 unsigned >=, 0x32 signed <, 0x33 unsigned <, 0x34 equal and 0x36 not equal compare the first source against the second. A true condition sets `trap`. A trap code never sets `wr_en`, and the shift field does not affect it.
- R6: An arithmetic, logic or set-on-less-than code (0x20..0x27, 0x2A, 0x2B) with a non-zero shift field sets `resv` and sets none of `wr_en`, `ovf` or `trap`.
- R7: Function codes 0x35 and 0x37 under major opcode zero set `resv` only.
- R8: Any non-zero major opcode, and any other function code, leaves all outputs low.
- R9: While `rst` is high at a rising edge, every output is cleared to zero.
- R10: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. At most one of `wr_en`, `ovf`, `trap` and `resv` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| result | output | 32 | Value to write back, zero when no write |
| wr_en | output | 1 | Destination register write enable |
| ovf | output | 1 | Signed arithmetic overflow occurred |
| trap | output | 1 | Trap condition was true |
| resv | output | 1 | Reserved encoding seen |

## Verification
Overflow is the hardest case to reach. Random operands almost never land right at the signed limits, and a single wrong boundary still passes on nearly every random pair. The stimulus therefore drives directed pairs at 0x7FFFFFFF+1, 0x80000000+0xFFFFFFFF, 0x80000000-1 and 0-0x80000000, along with the neighbouring pairs that just miss overflowing. It sends the same pairs through the wrapping codes and the compare codes, so that signed and unsigned boundary handling are each exercised where they diverge. A random phase then mixes all codes, shift fields and opcodes, and the behavioural model checks every cycle.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_LSB = 26;
    localparam int SHF_LSB = 6;
    localparam int SHF_W = 5;
    localparam int FN_W = 6;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 6'h20, FN_ADDU = 6'h21, FN_SUB  = 6'h22, FN_SUBU = 6'h23,
        FN_AND  = 6'h24, FN_OR   = 6'h25, FN_XOR  = 6'h26, FN_NOR  = 6'h27,
        FN_SLT  = 6'h2A, FN_SLTU = 6'h2B,
        FN_TGE  = 6'h30, FN_TGEU = 6'h31, FN_TLT  = 6'h32, FN_TLTU = 6'h33,
        FN_TEQ  = 6'h34, FN_RSV5 = 6'h35, FN_TNE  = 6'h36, FN_RSV7 = 6'h37
    } fn_e;

    typedef enum logic [2:0] {
        CL_NONE, CL_ARITH, CL_LOGIC, CL_SLT, CL_TRAP, CL_RSVD
    } cls_e;

    typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR, LG_NOR } lop_e;

    typedef enum logic [1:0] { TC_GE, TC_LT, TC_EQ, TC_NE } tcond_e;

    typedef struct packed {
        cls_e   cls;
        logic   is_sub;
        logic   chk_ovf;
        logic   uns;
        lop_e   lop;
        tcond_e tcond;
    } dec_t;

    localparam dec_t DEC_IDLE = '{cls: CL_NONE, is_sub: 1'b0, chk_ovf: 1'b0,
                                  uns: 1'b0, lop: LG_AND, tcond: TC_GE};

    function automatic logic needs_zero_shift(input logic [FN_W-1:0] fn);
        return (fn[5:3] == 3'b100) || (fn == FN_SLT) || (fn == FN_SLTU);
    endfunction

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [INSN_W-OPC_LSB-1:0] opc,
    input  logic [SHF_W-1:0]          shf,
    input  logic [FN_W-1:0]           fn,
    output dec_t                      dec
);
    always_comb begin
        dec = DEC_IDLE;
        if (opc == '0) begin
            if (needs_zero_shift(fn) && shf != '0) begin
                dec.cls = CL_RSVD;
            end else begin
                unique case (fn)
                    FN_ADD, FN_ADDU, FN_SUB, FN_SUBU: begin
                        dec.cls     = CL_ARITH;
                        dec.is_sub  = fn[1];
                        dec.chk_ovf = ~fn[0];
                    end
                    FN_AND, FN_OR, FN_XOR, FN_NOR: begin
                        dec.cls = CL_LOGIC;
                        dec.lop = lop_e'(fn[1:0]);
                    end
                    FN_SLT, FN_SLTU: begin
                        dec.cls    = CL_SLT;
                        dec.is_sub = 1'b1;
                        dec.uns    = fn[0];
                    end
                    FN_TGE, FN_TGEU, FN_TLT, FN_TLTU: begin
                        dec.cls    = CL_TRAP;
                        dec.is_sub = 1'b1;
                        dec.uns    = fn[0];
                        dec.tcond  = fn[1] ? TC_LT : TC_GE;
                    end
                    FN_TEQ, FN_TNE: begin
                        dec.cls   = CL_TRAP;
                        dec.tcond = fn[1] ? TC_NE : TC_EQ;
                    end
                    FN_RSV5, FN_RSV7: dec.cls = CL_RSVD;
                    default:          dec.cls = CL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_sub,
    output logic [XLEN-1:0] sum,
    output logic            ovf,
    output logic            lt_s,
    output logic            lt_u,
    output logic            eq
);
    localparam int EW = XLEN + 1;

    logic [EW-1:0] a_sx, b_sx, b_eff, ext;
    logic [EW-1:0] a_zx, b_zx, diff_u;

    always_comb begin
        a_sx  = {a[XLEN-1], a};
        b_sx  = {b[XLEN-1], b};
        b_eff = is_sub ? ~b_sx : b_sx;
        ext   = a_sx + b_eff + EW'(is_sub);
        sum   = ext[XLEN-1:0];
        ovf   = ext[XLEN] ^ ext[XLEN-1];
        lt_s  = ext[XLEN];
        a_zx  = {1'b0, a};
        b_zx  = {1'b0, b};
        diff_u = a_zx - b_zx;
        lt_u  = diff_u[XLEN];
        eq    = (a == b);
    end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  lop_e            lop,
    output logic [XLEN-1:0] y
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        always_comb begin
            unique case (lop)
                LG_AND:  y[i] = a[i] & b[i];
                LG_OR:   y[i] = a[i] | b[i];
                LG_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~(a[i] | b[i]);
            endcase
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic              ovf,
    output logic              trap,
    output logic              resv
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            wr;
        logic            ovf;
        logic            trap;
        logic            resv;
    } out_t;

    dec_t            dec;
    logic [XLEN-1:0] sum, lg_y;
    logic            as_ovf, lt_s, lt_u, eq, lt_sel;
    out_t            nxt, cur;
    logic            unused_insn_bits;

    assign unused_insn_bits = ^insn[OPC_LSB-1:SHF_LSB+SHF_W];

    int_alu_decode u_dec (
        .opc (insn[INSN_W-1:OPC_LSB]),
        .shf (insn[SHF_LSB+SHF_W-1:SHF_LSB]),
        .fn  (insn[FN_W-1:0]),
        .dec (dec)
    );

    int_alu_addsub #(.XLEN(XLEN)) u_as (
        .a(src_a), .b(src_b), .is_sub(dec.is_sub),
        .sum(sum), .ovf(as_ovf), .lt_s(lt_s), .lt_u(lt_u), .eq(eq)
    );

    int_alu_logic #(.XLEN(XLEN)) u_lg (
        .a(src_a), .b(src_b), .lop(dec.lop), .y(lg_y)
    );

    assign lt_sel = dec.uns ? lt_u : lt_s;

    always_comb begin
        nxt = '0;
        unique case (dec.cls)
            CL_ARITH: begin
                if (dec.chk_ovf && as_ovf) nxt.ovf = 1'b1;
                else begin
                    nxt.wr  = 1'b1;
                    nxt.res = sum;
                end
            end
            CL_LOGIC: begin
                nxt.wr  = 1'b1;
                nxt.res = lg_y;
            end
            CL_SLT: begin
                nxt.wr  = 1'b1;
                nxt.res = XLEN'(lt_sel);
            end
            CL_TRAP: begin
                unique case (dec.tcond)
                    TC_GE:   nxt.trap = ~lt_sel;
                    TC_LT:   nxt.trap = lt_sel;
                    TC_EQ:   nxt.trap = eq;
                    default: nxt.trap = ~eq;
                endcase
            end
            CL_RSVD: nxt.resv = 1'b1;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign result = cur.res;
    assign wr_en  = cur.wr;
    assign ovf    = cur.ovf;
    assign trap   = cur.trap;
    assign resv   = cur.resv;

    // R2: overflow suppresses the write
    p_ovf_blocks_write_r2: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (!wr_en && result == '0));

    // R3: wrapping codes never flag overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(insn[INSN_W-1:OPC_LSB]) == '0 &&
         ($past(insn[FN_W-1:0]) == FN_ADDU || $past(insn[FN_W-1:0]) == FN_SUBU))
        |-> !ovf);

    // R5: trap codes never write
    p_trap_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(insn[INSN_W-1:OPC_LSB]) == '0 && $past(insn[FN_W-1:4]) == 2'b11)
        |-> !wr_en);

    // R7: reserved flag stands alone
    p_resv_alone_r7: assert property (@(posedge clk) disable iff (rst)
        resv |-> (!wr_en && !ovf && !trap && result == '0));

    // R8: foreign major opcode is silent
    p_foreign_silent_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(insn[INSN_W-1:OPC_LSB]) != '0) |-> !(wr_en || ovf || trap || resv));

    // R10: at most one status output high
    p_status_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, ovf, trap, resv}));

endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0, src_a = '0, src_b = '0;
    logic [31:0] result;
    logic        wr_en, ovf, trap, resv;

    int checks = 0, bad = 0;
    bit finished = 0;

    logic [31:0] e_res;
    logic        e_w, e_o, e_t, e_v;
    string       e_tag;
    bit          e_valid = 0;

    always #2 clk = ~clk;

    int_alu u_int_alu (.clk(clk), .rst(rst), .insn(insn), .src_a(src_a), .src_b(src_b),
                       .result(result), .wr_en(wr_en), .ovf(ovf), .trap(trap), .resv(resv));

    function automatic logic [31:0] mk(input int fn, input int shf);
        return {6'd0, 5'd3, 5'd4, 5'd5, 5'(shf), 6'(fn)};
    endfunction

    task automatic model(input logic [31:0] i, a, b,
                         output logic [31:0] r, output logic w, o, t, v, output string tag);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint s;
        int fn = int'(i[5:0]);
        bit arith_like = (fn >= 'h20 && fn <= 'h27) || fn == 'h2A || fn == 'h2B;
        r = 0; w = 0; o = 0; t = 0; v = 0; tag = "R8";
        if (i[31:26] != 0) return;
        if (arith_like && i[10:6] != 0) begin v = 1; tag = "R6"; return; end
        case (fn)
            'h20, 'h22: begin
                s = (fn == 'h20) ? sa + sb : sa - sb;
                if (s > 64'sd2147483647 || s < -64'sd2147483648) begin o = 1; tag = "R2"; end
                else begin w = 1; r = s[31:0]; tag = "R1"; end
            end
            'h21: begin w = 1; r = a + b; tag = "R3"; end
            'h23: begin w = 1; r = a - b; tag = "R3"; end
            'h24: begin w = 1; r = a & b; tag = "R1"; end
            'h25: begin w = 1; r = a | b; tag = "R1"; end
            'h26: begin w = 1; r = a ^ b; tag = "R1"; end
            'h27: begin w = 1; r = ~(a | b); tag = "R1"; end
            'h2A: begin w = 1; r = (sa < sb) ? 1 : 0; tag = "R4"; end
            'h2B: begin w = 1; r = (ua < ub) ? 1 : 0; tag = "R4"; end
            'h30: begin t = (sa >= sb); tag = "R5"; end
            'h31: begin t = (ua >= ub); tag = "R5"; end
            'h32: begin t = (sa < sb); tag = "R5"; end
            'h33: begin t = (ua < ub); tag = "R5"; end
            'h34: begin t = (a == b); tag = "R5"; end
            'h36: begin t = (a != b); tag = "R5"; end
            'h35, 'h37: begin v = 1; tag = "R7"; end
            default: tag = "R8";
        endcase
    endtask

    task automatic compare(input string tag, input logic [31:0] xr,
                           input logic xw, xo, xt, xv);
        checks++;
        if (result !== xr || wr_en !== xw || ovf !== xo || trap !== xt || resv !== xv) begin
            bad++;
            $display("FAIL %s: got res=%h w=%b o=%b t=%b v=%b, want res=%h w=%b o=%b t=%b v=%b",
                     tag, result, wr_en, ovf, trap, resv, xr, xw, xo, xt, xv);
        end
    endtask

    task automatic drive(input logic [31:0] i, a, b);
        @(negedge clk);
        if (e_valid) compare(e_tag, e_res, e_w, e_o, e_t, e_v);
        insn = i; src_a = a; src_b = b;
        #1;
        if (e_valid) compare("R10 hold until edge", e_res, e_w, e_o, e_t, e_v);
        model(i, a, b, e_res, e_w, e_o, e_t, e_v, e_tag);
        e_valid = 1;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            bad++;
            $display("FAIL R10 watchdog expired: got running, want done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset clears while a writing op is presented
        insn = mk('h25, 0); src_a = 32'hFFFF_0000; src_b = 32'h0000_FFFF;
        repeat (3) @(negedge clk);
        compare("R9 reset state", 32'd0, 0, 0, 0, 0);
        rst = 1'b0;

        // R1 logic and basic arithmetic
        drive(mk('h20, 0), 32'd5, 32'd7);
        drive(mk('h24, 0), 32'hF0F0_1234, 32'h0FF0_FF00);
        drive(mk('h25, 0), 32'hF000_0001, 32'h0000_1002);
        drive(mk('h26, 0), 32'hAAAA_5555, 32'hFFFF_0000);
        drive(mk('h27, 0), 32'h1234_5678, 32'd0);      // R1 NOR as NOT
        drive(mk('h22, 0), 32'd3, 32'd10);
        // R2 boundaries
        drive(mk('h20, 0), 32'h7FFF_FFFF, 32'd1);
        drive(mk('h20, 0), 32'h7FFF_FFFE, 32'd1);
        drive(mk('h20, 0), 32'h8000_0000, 32'hFFFF_FFFF);
        drive(mk('h20, 0), 32'h8000_0000, 32'd0);
        drive(mk('h22, 0), 32'h8000_0000, 32'd1);
        drive(mk('h22, 0), 32'd0, 32'h8000_0000);
        drive(mk('h22, 0), 32'hFFFF_FFFF, 32'h8000_0000);
        // R3 wrapping with same pairs
        drive(mk('h21, 0), 32'h7FFF_FFFF, 32'd1);
        drive(mk('h21, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive(mk('h23, 0), 32'h8000_0000, 32'd1);
        drive(mk('h23, 0), 32'd0, 32'h8000_0000);
        // R4 compares
        drive(mk('h2A, 0), 32'hFFFF_FFFF, 32'd1);
        drive(mk('h2B, 0), 32'hFFFF_FFFF, 32'd1);
        drive(mk('h2A, 0), 32'h7FFF_FFFF, 32'h8000_0000);
        drive(mk('h2B, 0), 32'h7FFF_FFFF, 32'h8000_0000);
        drive(mk('h2A, 0), 32'd9, 32'd9);
        // R5 traps, equal and boundary operands
        for (int fn = 'h30; fn <= 'h36; fn++) begin
            if (fn == 'h35) continue;
            drive(mk(fn, 0), 32'd4, 32'd4);
            drive(mk(fn, 7), 32'hFFFF_FFFF, 32'd0);
            drive(mk(fn, 0), 32'd0, 32'hFFFF_FFFF);
            drive(mk(fn, 0), 32'h8000_0000, 32'h7FFF_FFFF);
        end
        // R6 non-zero shift field, R7 reserved trap slots
        drive(mk('h20, 1), 32'h7FFF_FFFF, 32'd1);
        drive(mk('h27, 31), 32'd0, 32'd0);
        drive(mk('h2B, 4), 32'd0, 32'd1);
        drive(mk('h35, 0), 32'd1, 32'd1);
        drive(mk('h37, 2), 32'd1, 32'd2);
        // R8 other function codes and opcodes
        drive(mk('h00, 0), 32'd1, 32'd2);
        drive(mk('h28, 0), 32'd1, 32'd2);
        drive(mk('h3F, 0), 32'd1, 32'd2);
        drive(mk('h21, 0) | 32'h0400_0000, 32'd1, 32'd2);
        drive(mk('h30, 0) | 32'h8000_0000, 32'd5, 32'd5);

        // random mix across all codes, shift fields and edge operands
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] i, a, b;
            int sel = $urandom_range(0, 9);
            i = {6'd0, 20'($urandom), 6'($urandom_range('h20, 'h37))};
            if (sel < 6) i[10:6] = 5'd0;
            if (sel == 9) i[31:26] = 6'($urandom_range(1, 63));
            a = $urandom; b = $urandom;
            if (sel == 1) a = {a[31], {31{~a[31]}}};
            if (sel == 2) b = a;
            if (sel == 3) b = {b[31], {31{~b[31]}}};
            drive(i, a, b);
        end
        drive(32'hFFFF_FFFF, 32'd0, 32'd0);
        drive(32'd0, 32'd0, 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule